// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight asynchronous interrupt request lines into a registered pending vector. Each line has its own trigger-mode bit, chosen at run time. A line in level mode reports a request for as long as its input is high. A line in edge mode reports a request once for each low-to-high transition, and keeps reporting it until it is acknowledged.

Downstream logic picks a line and pulses an acknowledge with that line's index. The acknowledge retires an edge-mode request. A level-mode request is left pending, because only the source can withdraw it by dropping its line. The trigger-mode bits are written and read through a byte-wide port. A fixed per-instance mask decides which bits software may set, and the bits outside the mask always stay in edge mode.

Top module: `irq_req_latch`

## Requirements
- R1: After reset, `irr_o` is 0 and `mode_rdata_o` is 0, so every line starts in edge mode.
- R2: A write stores `mode_wdata_o & WR_MASK`, and `mode_rdata_o` returns the stored value from the next cycle on. With the default `WR_MASK` = 8'hDE, bits 0 and 5 always read 0, and their lines stay in edge mode. Mode bit i = 1 selects level sensing for line i, and 0 selects edge sensing.
- R3: In level mode, `irr_o[i]` follows `req_i[i]`. A change on `req_i` appears on `irr_o` after the third rising clock edge: two synchroniser stages, then the request register.
- R4: In edge mode, a low-to-high transition of `req_i[i]` sets `irr_o[i]` with the same three-edge latency, and the bit stays set after the input falls.
- R5: In edge mode, an input that stays high requests only once. After an acknowledge, the line must go low and then high again before `irr_o[i]` sets again.
- R6: An acknowledge (`ack_i` high, `ack_idx_i` = i) on an edge-mode line clears `irr_o[i]` on the next clock edge.
- R7: An acknowledge on a level-mode line leaves `irr_o[i]` unchanged while its input is high.
- R8: When a new rising edge on an edge-mode line is detected on the same clock edge as an acknowledge of that line, the new request wins and `irr_o[i]` stays set.
- R9: An acknowledge of line j changes no other bit of `irr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | N_LINES | Asynchronous interrupt request lines |
| ack_i | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| ack_idx_i | input | IDX_W | Index of the line being acknowledged |
| mode_wr_i | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata_o | input | N_LINES | Trigger-mode write data (1 = level, 0 = edge) |
| mode_rdata_o | output | N_LINES | Stored trigger-mode value |
| irr_o | output | N_LINES | Pending request vector |

## Verification
The assertions assume three things: no mode write and no acknowledge arrive in the two cycles after reset is released, while the internal reset is still being synchronised; each acknowledge is a single-cycle strobe; and `ack_idx_i` names an existing line. The stimulus waits several cycles after reset before it does anything. It drives every input on the falling clock edge, holds each acknowledge and each write for exactly one cycle, and only acknowledges indices 0 to 7. Request inputs change only on falling edges, so the synchroniser sees clean levels, and the bench can predict the three-edge latency exactly.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int unsigned          WIDTH   = 8,
  parameter logic [WIDTH-1:0]     WR_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mode_o
);
  logic [WIDTH-1:0] mode_q;
  logic [WIDTH-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en_i) begin
      mode_d = wdata_i & WR_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  trig_e trig_i,
  input  logic  ack_hit_i,
  output logic  pend_o,
  output logic  prev_o
);
  logic pend_q, pend_d;
  logic prev_q, prev_d;
  logic rise;

  assign rise = lvl_i & ~prev_q;

  always_comb begin
    prev_d = lvl_i;
    pend_d = pend_q;
    unique case (trig_i)
      TRIG_LEVEL: pend_d = lvl_i;
      TRIG_EDGE: begin
        if (rise) begin
          pend_d = 1'b1;
        end else if (ack_hit_i) begin
          pend_d = 1'b0;
        end
      end
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  assign pend_o = pend_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned            N_LINES = 8,
  parameter logic [N_LINES-1:0]     WR_MASK = 8'hDE,
  localparam int unsigned           IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  input  logic               mode_wr_i,
  input  logic [N_LINES-1:0] mode_wdata_o,
  output logic [N_LINES-1:0] mode_rdata_o,
  output logic [N_LINES-1:0] irr_o
);
  logic               rst_n_sync;
  logic [N_LINES-1:0] req_sync;
  logic [N_LINES-1:0] prev_vec;
  logic [N_LINES-1:0] mode_vec;
  logic [N_LINES-1:0] ack_vec;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  irq_sync2 #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) i_req_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .async_i (req_i),
    .sync_o  (req_sync)
  );

  irq_mode_reg #(.WIDTH(N_LINES), .WR_MASK(WR_MASK)) i_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .wr_en_i (mode_wr_i),
    .wdata_i (mode_wdata_o),
    .mode_o  (mode_vec)
  );

  always_comb begin
    ack_vec = '0;
    if (ack_i) begin
      ack_vec[ack_idx_i] = 1'b1;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    irq_line_cell i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_sync),
      .lvl_i     (req_sync[i]),
      .trig_i    (trig_e'(mode_vec[i])),
      .ack_hit_i (ack_vec[i]),
      .pend_o    (irr_o[i]),
      .prev_o    (prev_vec[i])
    );
  end

  assign mode_rdata_o = mode_vec;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int unsigned        N_LINES = 8,
  parameter logic [N_LINES-1:0] WR_MASK = 8'hDE,
  localparam int unsigned       IDX_W   = $clog2(N_LINES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic [IDX_W-1:0]   ack_idx_i,
  input logic               mode_wr_i,
  input logic [N_LINES-1:0] mode_wdata_o,
  input logic [N_LINES-1:0] mode_rdata_o,
  input logic [N_LINES-1:0] irr_o,
  input logic [N_LINES-1:0] sync_lvl,
  input logic [N_LINES-1:0] prev_lvl
);
  logic [N_LINES-1:0] ack_onehot;
  logic [N_LINES-1:0] rise_vec;

  always_comb begin
    ack_onehot = '0;
    if (ack_i) ack_onehot[ack_idx_i] = 1'b1;
  end
  assign rise_vec = sync_lvl & ~prev_lvl;

  assert_mode_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> mode_rdata_o == $past(mode_wdata_o & WR_MASK));

  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr_i |=> $stable(mode_rdata_o));

  assert_level_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irr_o ^ $past(sync_lvl)) & $past(mode_rdata_o)) == '0);

  assert_edge_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (~irr_o & $past(~mode_rdata_o & rise_vec)) == '0);

  assert_edge_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irr_o & $past(~mode_rdata_o & ~rise_vec & ack_onehot)) == '0);

  // R9: an edge-mode bit with no new edge and no acknowledge keeps its value
  assert_edge_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irr_o ^ $past(irr_o)) & $past(~mode_rdata_o & ~rise_vec & ~ack_onehot)) == '0);
endmodule

bind irq_req_latch irq_req_latch_chk #(.N_LINES(N_LINES), .WR_MASK(WR_MASK)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_i        (ack_i),
  .ack_idx_i    (ack_idx_i),
  .mode_wr_i    (mode_wr_i),
  .mode_wdata_o (mode_wdata_o),
  .mode_rdata_o (mode_rdata_o),
  .irr_o        (irr_o),
  .sync_lvl     (req_sync),
  .prev_lvl     (prev_vec)
);

// File: tb/test_irq_req_latch.sv
module test_irq_req_latch;
  logic       clk;
  logic       rst_n;
  logic [7:0] req;
  logic       ack;
  logic [2:0] ack_idx;
  logic       mode_wr;
  logic [7:0] mode_wdata;
  logic [7:0] mode_rdata;
  logic [7:0] irr;

  int checks;
  int failures;
  bit done;

  irq_req_latch i_irq_req_latch (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .ack_i        (ack),
    .ack_idx_i    (ack_idx),
    .mode_wr_i    (mode_wr),
    .mode_wdata_o (mode_wdata),
    .mode_rdata_o (mode_rdata),
    .irr_o        (irr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    nedge(1);
    mode_wr = 1'b0;
  endtask

  task automatic do_ack(input logic [2:0] idx);
    ack = 1'b1; ack_idx = idx;
    nedge(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    nedge(1);
    chk("R1 irr after reset", irr, 8'h00);
    chk("R1 mode after reset", mode_rdata, 8'h00);
  endtask

  task automatic t_mask();
    write_mode(8'hFF);
    chk("R2 masked write FF", mode_rdata, 8'hDE);
    write_mode(8'h23);
    chk("R2 masked write 23", mode_rdata, 8'h02);
    req[0] = 1'b1; nedge(3);
    req[0] = 1'b0; nedge(3);
    chk("R2 unwritable line 0 stays edge", irr, 8'h01);
    do_ack(3'd0);
    chk("R2 line 0 cleared by ack", irr, 8'h00);
  endtask

  task automatic t_level();
    req[1] = 1'b1; nedge(2);
    chk("R3 latency two edges", irr, 8'h00);
    nedge(1);
    chk("R3 level set at third edge", irr, 8'h02);
    do_ack(3'd1);
    chk("R7 ack on level line ignored", irr, 8'h02);
    req[1] = 1'b0; nedge(3);
    chk("R3 level clears with input", irr, 8'h00);
  endtask

  task automatic t_edge();
    req[3] = 1'b1; nedge(3);
    chk("R4 edge sets", irr, 8'h08);
    req[3] = 1'b0; nedge(3);
    chk("R4 edge holds after fall", irr, 8'h08);
    do_ack(3'd4);
    chk("R9 ack other line no effect", irr, 8'h08);
    do_ack(3'd3);
    chk("R6 ack clears edge line", irr, 8'h00);
  endtask

  task automatic t_held();
    req[6] = 1'b1; nedge(3);
    chk("R5 first request", irr, 8'h40);
    do_ack(3'd6);
    nedge(5);
    chk("R5 held high no re-request", irr, 8'h00);
    req[6] = 1'b0; nedge(3);
    req[6] = 1'b1; nedge(3);
    chk("R5 new edge re-requests", irr, 8'h40);
    req[6] = 1'b0;
    do_ack(3'd6);
    nedge(3);
    chk("R5 cleared", irr, 8'h00);
  endtask

  task automatic t_collide();
    req[3] = 1'b1; nedge(3);
    req[3] = 1'b0; nedge(4);
    chk("R8 pending before collision", irr, 8'h08);
    req[3] = 1'b1; nedge(2);
    ack = 1'b1; ack_idx = 3'd3;
    nedge(1);
    ack = 1'b0;
    chk("R8 new edge wins over ack", irr, 8'h08);
    do_ack(3'd3);
    chk("R6 later ack clears", irr, 8'h00);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; req = '0; ack = 1'b0; ack_idx = '0;
    mode_wr = 1'b0; mode_wdata = '0;
    nedge(3);
    rst_n = 1'b1;
    nedge(5);
    t_reset();
    t_mask();
    t_level();
    t_edge();
    t_held();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule